// File: doc/BRIEF.md
# Transition-Count Signature Analyzer

This block compresses the serial response stream of a circuit under test into a single number. That number is how many times the stream changed level over a test window. Each clock in which the sample enable is high, the block takes the new response bit and compares it with the bit it kept from the previous enabled sample. Whenever the two bits differ, in either direction, a counter goes up by one.

When the window closes, the test controller pulses a done strobe and drives the known-good count on a separate input. The block then freezes the accumulated count, which is the signature. It compares the signature with the expected value and raises a pass flag or a fail flag. The flag stays valid until the next reset. The counter is wide enough for the expected test length. If a stream has more transitions than the counter can hold, the counter pins at its top value and does not wrap, so an overflowing stream cannot alias to a small count.

Top module: `tcount_sig`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears the count to 0 and drops both `pass` and `fail` to 0. It also forgets the previous bit.
- R2: The first enabled sample after reset only loads the previous-bit store and never changes the count.
- R3: An enabled sample of 1 that follows an enabled sample of 0 raises the count by exactly 1 after that edge.
- R4: An enabled sample of 0 that follows an enabled sample of 1 raises the count by exactly 1 after that edge.
- R5: An enabled sample equal to the previous enabled sample leaves the count unchanged.
- R6: While `smp_en` is low, both the count and the stored previous bit hold, whatever `din` does. The next enabled sample is compared with the last enabled one.
- R7: With `CNT_W` bits (default 8), the count stops at 2^CNT_W-1 (255 by default) and never wraps.
- R8: A `done` pulse makes `pass`=1 and `fail`=0 on the cycle after it, provided `count` equals `exp_cnt` at that edge. A sample offered in the same cycle as `done` is discarded.
- R9: A `done` pulse makes `fail`=1 and `pass`=0 on the cycle after it if `count` differs from `exp_cnt` at that edge.
- R10: After a verdict, `count`, `pass` and `fail` hold until reset. Later samples and later `done` pulses have no effect.
- R11: `pass` and `fail` are never high together, and both stay 0 until the first `done` after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Take `din` as a response sample this cycle |
| din | input | 1 | Serial response bit |
| exp_cnt | input | CNT_W | Known-good transition count, read on `done` |
| done | input | 1 | End of test window; freezes count and produces verdict |
| count | output | CNT_W | Accumulated transition count (signature) |
| pass | output | 1 | Signature matched expected value |
| fail | output | 1 | Signature differed from expected value |

## Verification
The counter is driven with four kinds of stream:
- **Steady stream.** It tells a real transition apart from a repeated bit.
- **Single rise and single fall.** These show that both directions count.
- **Stream with enable gaps while `din` toggles.** It proves the comparison skips over unsampled cycles.
- **Long alternating stream.** It drives the counter past its top value to separate saturation from wraparound.

The verdict is tried with a matching and a mismatching expected count. After each verdict, extra toggling and a second `done` show that the frozen result cannot be disturbed.

// File: rtl/tcount_sig.sv
module tcount_sig #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_en,
  input  logic             din,
  input  logic [CNT_W-1:0] exp_cnt,
  input  logic             done,
  output logic [CNT_W-1:0] count,
  output logic             pass,
  output logic             fail
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             prev_q;
  logic             primed_q;
  logic             frozen_q;
  logic             pass_q;
  logic             fail_q;
  logic [CNT_W-1:0] cnt_q;

  wire take      = smp_en && !frozen_q;
  wire toggled   = primed_q && (din != prev_q);
  wire at_max    = (cnt_q == CNT_MAX);
  wire judge_now = done && !frozen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
      frozen_q <= 1'b0;
      pass_q   <= 1'b0;
      fail_q   <= 1'b0;
      cnt_q    <= '0;
    end else if (judge_now) begin
      frozen_q <= 1'b1;
      pass_q   <= (cnt_q == exp_cnt);
      fail_q   <= (cnt_q != exp_cnt);
    end else if (take) begin
      prev_q   <= din;
      primed_q <= 1'b1;
      if (toggled && !at_max)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count = cnt_q;
  assign pass  = pass_q;
  assign fail  = fail_q;

  // R11
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pass_q && fail_q));

  // R3 / R4: at most one step per edge
  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

  // R6
  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!smp_en && !done) |=> $stable(cnt_q));

  // R7
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    at_max |=> at_max);

  // R8 / R9: verdict only arises from a done pulse
  a_r8_verdict_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(pass_q || fail_q) |-> $past(done));

  // R10
  a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
    (pass_q || fail_q) |=> $stable(cnt_q) && $stable(pass_q) && $stable(fail_q));
endmodule

// File: tb/tcount_sig_test.sv
module tcount_sig_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         smp_en = 1'b0;
  logic         din = 1'b0;
  logic [W-1:0] exp_cnt = '0;
  logic         done = 1'b0;
  logic [W-1:0] count;
  logic         pass;
  logic         fail;

  int n_checks = 0;
  int n_fail = 0;

  tcount_sig #(.CNT_W(W)) uut (
    .clk(clk), .rst(rst), .smp_en(smp_en), .din(din),
    .exp_cnt(exp_cnt), .done(done), .count(count), .pass(pass), .fail(fail)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; smp_en = 1'b0; done = 1'b0;
    step();
    rst = 1'b0;
  endtask

  task automatic send(input logic b);
    smp_en = 1'b1; din = b;
    step();
    smp_en = 1'b0;
  endtask

  task automatic finish_window(input int expected);
    exp_cnt = expected[W-1:0]; done = 1'b1;
    step();
    done = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 count", count, 0);
    check("R1 pass", pass, 0);
    check("R11 fail low before done", fail, 0);
  endtask

  task automatic t_edges();
    do_reset();
    send(1'b1);
    check("R2 first sample", count, 0);
    send(1'b1);
    check("R5 repeat bit", count, 0);
    send(1'b0);
    check("R4 falling", count, 1);
    send(1'b1);
    check("R3 rising", count, 2);
  endtask

  task automatic t_enable_gap();
    do_reset();
    send(1'b0);
    send(1'b1);
    check("R3 rise before gap", count, 1);
    for (int i = 0; i < 4; i++) begin
      din = i[0];
      step();
    end
    check("R6 hold while disabled", count, 1);
    send(1'b1);
    check("R6 prev bit held", count, 1);
    send(1'b0);
    check("R6 resume compare", count, 2);
  endtask

  task automatic t_pass();
    do_reset();
    send(1'b0); send(1'b1); send(1'b0); send(1'b1); send(1'b1); send(1'b0);
    check("R3 R4 mixed", count, 4);
    check("R11 no verdict yet", pass, 0);
    finish_window(4);
    check("R8 pass", pass, 1);
    check("R8 fail low", fail, 0);
    send(1'b1); send(1'b0); send(1'b1);
    finish_window(9);
    check("R10 count frozen", count, 4);
    check("R10 pass held", pass, 1);
    check("R10 fail held", fail, 0);
  endtask

  task automatic t_fail();
    do_reset();
    send(1'b1); send(1'b0); send(1'b0); send(1'b1); send(1'b0);
    check("R9 count", count, 3);
    smp_en = 1'b1; din = 1'b1;
    finish_window(5);
    smp_en = 1'b0;
    check("R9 fail", fail, 1);
    check("R11 pass low", pass, 0);
    check("R8 sample in done cycle dropped", count, 3);
    do_reset();
    check("R1 verdict cleared", fail, 0);
  endtask

  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < 300; i++) send(i[0]);
    check("R7 saturate", count, 255);
    send(1'b0);
    check("R7 no wrap", count, 255);
    finish_window(255);
    check("R8 pass at max", pass, 1);
  endtask

  initial begin
    #(10 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_edges();
    t_enable_gap();
    t_pass();
    t_fail();
    t_saturate();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule